// File: doc/BRIEF.md
# Mailbox Sender Frame

The block is the transmitting side of a point-to-point mailbox. It holds a set of 32-bit channel windows. Software can only raise bits in a window's status word, through a set register that ORs the written value in. The status words go out continuously on a link to a receiving frame. The receiver clears them again by sending clear requests back: a window index and a bit mask. A window counts as idle, meaning its last transmit is complete, when its status word is zero.

Each window has a transmit-done flag. The flag is raised when a receiver clear takes that window's status from nonzero to zero. It is enabled per window and cleared by a write. The enabled flags are collected into a combined bitmap, and the bitmap is ORed into a single sender interrupt that is gated by a global enable. Two more kinds of register complete the block. An access request/ready handshake decides whether set writes reach the status words. Read-only registers report the window count and the architecture revision.

Top module: `mbx_sender_frame`

## Requirements
- R1: Window w uses the addresses w*0x20 through w*0x20+0x1F. Its status word reads back at offset 0x00, and all its other offsets read zero except 0x10 and 0x18. After reset every status word is zero.
- R2: A write to a window's set register (offset 0x0C) ORs the written data into that window's status word. Data bits written as zero change nothing. Status bits never rise without such a write.
- R3: When rx_clr_en is high, the bits given by rx_clr_mask are cleared in window rx_clr_win. A bit that is set and cleared in the same cycle ends up set. lnk_stat carries window w's status word in bits [w*32+31:w*32], starting the cycle after the change.
- R4: The register at 0xF80 reads NWIN in bits [6:0]. The register at 0xFCC reads MINOR_REV in bits [3:0] and MAJOR_REV in bits [7:4].
- R5: A window's done flag (bit 0 at offset 0x10) is set in the same cycle that a receiver clear takes its status word from nonzero to zero. Writing 1 to bit 0 at offset 0x14 clears the flag, but a done event in the same cycle takes priority.
- R6: Bit 0 at offset 0x18 is a read/write per-window interrupt enable. Combined register k at 0xFA0+4*k holds, in bit j, the done flag ANDed with the enable of window 32*k+j. The irq output is the OR of all combined bits, gated by bit 2 of the read/write register at 0xF98.
- R7: Set-register writes are dropped while the access-ready bit is 0.
- R8: Bit 0 of 0xF88 is the read/write access request and drives lnk_req. Bit 0 of 0xF8C reads access ready, which is the request ANDed with lnk_ready, registered once. Writing 0 to the request drops ready one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 12 | Byte address of the register access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| lnk_stat | output | NWIN*32 | All window status words toward the receiver |
| lnk_req | output | 1 | Access request toward the receiver |
| lnk_ready | input | 1 | Receiver ready to accept access |
| rx_clr_en | input | 1 | Receiver clear request valid |
| rx_clr_win | input | 7 | Window addressed by the clear request |
| rx_clr_mask | input | 32 | Status bits to clear |
| irq | output | 1 | Combined transmit-done interrupt |

## Verification
The assertions assume that a status bit can rise only through a bus write, so they treat any other rise as an error. They also assume that a done flag can appear only in the cycle after a receiver clear. The stimulus keeps to this by issuing at most one bus write and one receiver clear per cycle. Clears always target an implemented window, and the receiver ready input changes only during the directed handshake phase. In the random phase, writes are spread over the set, flag-clear, enable and global-enable registers, and some clears coincide with sets on the same window.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
    localparam int WIDX_W    = 7;
    localparam int WORD_W    = 32;
    localparam int COMB_REGS = 4;

    localparam logic [4:0] OFS_STAT = 5'h00;
    localparam logic [4:0] OFS_SET  = 5'h0C;
    localparam logic [4:0] OFS_DONE = 5'h10;
    localparam logic [4:0] OFS_DCLR = 5'h14;
    localparam logic [4:0] OFS_DEN  = 5'h18;

    localparam logic [11:0] A_CFG   = 12'hF80;
    localparam logic [11:0] A_AREQ  = 12'hF88;
    localparam logic [11:0] A_ARDY  = 12'hF8C;
    localparam logic [11:0] A_GEN   = 12'hF98;
    localparam logic [11:0] A_COMB0 = 12'hFA0;
    localparam logic [11:0] A_ARCH  = 12'hFCC;
    localparam int          GEN_COMB_BIT = 2;

    typedef struct packed {
        logic [WORD_W-1:0] stat;
        logic              done;
        logic              den;
    } win_state_t;

    typedef struct packed {
        logic req;
        logic rdy;
        logic comb_en;
    } acc_state_t;
endpackage

// File: rtl/mbx_tx_window.sv
module mbx_tx_window
    import mbx_pkg::*;
#(
    parameter bit HAS_IRQ = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_we,
    input  logic [WORD_W-1:0] set_val,
    input  logic              dclr_we,
    input  logic              dclr_bit,
    input  logic              den_we,
    input  logic              den_bit,
    input  logic              rclr_en,
    input  logic [WORD_W-1:0] rclr_mask,
    output logic [WORD_W-1:0] stat,
    output logic              done,
    output logic              den
);
    win_state_t s_d, s_q;
    logic       empties;

    always_comb begin
        s_d      = s_q;
        s_d.stat = (s_q.stat & ~(rclr_en ? rclr_mask : '0))
                 | (set_we ? set_val : '0);
        empties  = (s_q.stat != '0) && (s_d.stat == '0);
        if (HAS_IRQ) begin
            if (empties)
                s_d.done = 1'b1;
            else if (dclr_we && dclr_bit)
                s_d.done = 1'b0;
            if (den_we)
                s_d.den = den_bit;
        end else begin
            s_d.done = 1'b0;
            s_d.den  = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign stat = s_q.stat;
    assign done = s_q.done;
    assign den  = s_q.den;
endmodule

// File: rtl/mbx_tx_access.sv
module mbx_tx_access
    import mbx_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_we,
    input  logic req_bit,
    input  logic gen_we,
    input  logic gen_bit,
    input  logic link_ready,
    output logic req,
    output logic rdy,
    output logic comb_en
);
    acc_state_t a_d, a_q;

    always_comb begin
        a_d     = a_q;
        a_d.rdy = a_q.req & link_ready;
        if (req_we) a_d.req     = req_bit;
        if (gen_we) a_d.comb_en = gen_bit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

    assign req     = a_q.req;
    assign rdy     = a_q.rdy;
    assign comb_en = a_q.comb_en;
endmodule

// File: rtl/mbx_sender_frame.sv
module mbx_sender_frame
    import mbx_pkg::*;
#(
    parameter int NWIN      = 4,
    parameter int MINOR_REV = 1,
    parameter int MAJOR_REV = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_we,
    input  logic [11:0]            bus_addr,
    input  logic [31:0]            bus_wdata,
    output logic [31:0]            bus_rdata,
    output logic [NWIN*WORD_W-1:0] lnk_stat,
    output logic                   lnk_req,
    input  logic                   lnk_ready,
    input  logic                   rx_clr_en,
    input  logic [WIDX_W-1:0]      rx_clr_win,
    input  logic [31:0]            rx_clr_mask
,   output logic                   irq
);
    localparam bit HAS_IRQ = (MINOR_REV >= 1);
    localparam int COMB_W  = COMB_REGS * WORD_W;

    logic [WIDX_W-1:0] win_idx;
    logic [4:0]        win_ofs;
    logic              win_hit;
    logic              acc_req, acc_rdy, comb_en;
    logic [NWIN-1:0]   done_v, den_v;
    logic [COMB_W-1:0] comb_vec;

    assign win_idx = bus_addr[11:5];
    assign win_ofs = bus_addr[4:0];
    assign win_hit = (int'(win_idx) < NWIN);

    mbx_tx_access u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_we     (bus_we && bus_addr == A_AREQ),
        .req_bit    (bus_wdata[0]),
        .gen_we     (bus_we && bus_addr == A_GEN),
        .gen_bit    (bus_wdata[GEN_COMB_BIT]),
        .link_ready (lnk_ready),
        .req        (acc_req),
        .rdy        (acc_rdy),
        .comb_en    (comb_en)
    );

    for (genvar w = 0; w < NWIN; w++) begin : g_win
        logic sel;
        assign sel = win_hit && (int'(win_idx) == w);
        mbx_tx_window #(.HAS_IRQ(HAS_IRQ)) u_win (
            .clk       (clk),
            .rst_n     (rst_n),
            .set_we    (bus_we && sel && win_ofs == OFS_SET && acc_rdy),
            .set_val   (bus_wdata),
            .dclr_we   (bus_we && sel && win_ofs == OFS_DCLR),
            .dclr_bit  (bus_wdata[0]),
            .den_we    (bus_we && sel && win_ofs == OFS_DEN),
            .den_bit   (bus_wdata[0]),
            .rclr_en   (rx_clr_en && int'(rx_clr_win) == w),
            .rclr_mask (rx_clr_mask),
            .stat      (lnk_stat[w*WORD_W +: WORD_W]),
            .done      (done_v[w]),
            .den       (den_v[w])
        );
    end

    always_comb begin
        comb_vec = '0;
        for (int w = 0; w < NWIN; w++)
            comb_vec[w] = done_v[w] & den_v[w];
    end

    assign irq     = comb_en & (|comb_vec);
    assign lnk_req = acc_req;

    always_comb begin
        bus_rdata = '0;
        if (win_hit) begin
            for (int w = 0; w < NWIN; w++) begin
                if (int'(win_idx) == w) begin
                    case (win_ofs)
                        OFS_STAT: bus_rdata = lnk_stat[w*WORD_W +: WORD_W];
                        OFS_DONE: bus_rdata = {31'b0, done_v[w]};
                        OFS_DEN:  bus_rdata = {31'b0, den_v[w]};
                        default:  bus_rdata = '0;
                    endcase
                end
            end
        end else begin
            case (bus_addr)
                A_CFG:   bus_rdata = {25'b0, 7'(NWIN)};
                A_AREQ:  bus_rdata = {31'b0, acc_req};
                A_ARDY:  bus_rdata = {31'b0, acc_rdy};
                A_GEN:   bus_rdata = 32'(comb_en) << GEN_COMB_BIT;
                A_ARCH:  bus_rdata = {24'b0, 4'(MAJOR_REV), 4'(MINOR_REV)};
                default: begin
                    for (int k = 0; k < COMB_REGS; k++)
                        if (bus_addr == A_COMB0 + 12'(4*k))
                            bus_rdata = comb_vec[k*WORD_W +: WORD_W];
                end
            endcase
        end
    end
endmodule

// File: rtl/mbx_sender_frame_chk.sv
module mbx_sender_frame_chk #(
    parameter int NWIN = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_we,
    input logic             rx_clr_en,
    input logic             acc_rdy,
    input logic             acc_req,
    input logic             comb_en,
    input logic             irq,
    input logic [NWIN*32-1:0] stat_all,
    input logic [NWIN-1:0]  done_all
);
    // R2: status bits only rise after a bus write
    p_rise_needs_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_we |=> ((stat_all & ~$past(stat_all)) == '0));

    // R7: with access not ready and no receiver clear, status holds
    p_set_blocked_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!acc_rdy && !rx_clr_en) |=> $stable(stat_all));

    // R5: a done flag only appears in the cycle after a receiver clear
    p_done_after_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ((done_all & ~$past(done_all)) != '0) |-> $past(rx_clr_en));

    // R6: interrupt stays low while the global combined enable is off
    p_irq_gated_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !comb_en |-> !irq);

    // R8: ready only follows a request held in the previous cycle
    p_ready_after_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        acc_rdy |-> $past(acc_req));
endmodule

bind mbx_sender_frame mbx_sender_frame_chk #(.NWIN(NWIN)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .rx_clr_en (rx_clr_en),
    .acc_rdy   (acc_rdy),
    .acc_req   (acc_req),
    .comb_en   (comb_en),
    .irq       (irq),
    .stat_all  (lnk_stat),
    .done_all  (done_v)
);

// File: tb/sim_mbx_sender_frame.sv
module sim_mbx_sender_frame;
    localparam int NWIN = 4;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_we = 1'b0;
    logic [11:0]       bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic [NWIN*32-1:0] lnk_stat;
    logic              lnk_req;
    logic              lnk_ready = 1'b1;
    logic              rx_clr_en = 1'b0;
    logic [6:0]        rx_clr_win = '0;
    logic [31:0]       rx_clr_mask = '0;
    logic              irq;

    int nchk = 0;
    int nfail = 0;

    logic [31:0] m_stat [NWIN];
    bit          m_done [NWIN];
    bit          m_den  [NWIN];
    bit          m_req, m_rdy, m_cen;

    always #10 clk = ~clk;

    mbx_sender_frame #(.NWIN(NWIN), .MINOR_REV(1), .MAJOR_REV(2)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .lnk_stat(lnk_stat),
        .lnk_req(lnk_req), .lnk_ready(lnk_ready), .rx_clr_en(rx_clr_en),
        .rx_clr_win(rx_clr_win), .rx_clr_mask(rx_clr_mask), .irq(irq)
    );

    function automatic logic [11:0] wa(int w, logic [4:0] ofs);
        return {w[6:0], ofs};
    endfunction

    function automatic logic [31:0] exp_comb();
        logic [31:0] v = '0;
        for (int w = 0; w < NWIN; w++) v[w] = m_done[w] & m_den[w];
        return v;
    endfunction

    function automatic logic exp_irq();
        return m_cen && (exp_comb() != '0);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
        bus_we = 1'b0;
        bus_addr = a;
        #1;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic cyc(bit we, logic [11:0] a, logic [31:0] d,
                       bit ce, int cw, logic [31:0] cm);
        logic [31:0] nxt;
        bit nrdy;
        bus_we = we; bus_addr = a; bus_wdata = d;
        rx_clr_en = ce; rx_clr_win = cw[6:0]; rx_clr_mask = cm;
        @(posedge clk);
        for (int w = 0; w < NWIN; w++) begin
            nxt = m_stat[w] & ~((ce && cw == w) ? cm : 32'h0);
            if (we && m_rdy && a == wa(w, 5'h0C)) nxt = nxt | d;
            if (m_stat[w] != 0 && nxt == 0) m_done[w] = 1'b1;
            else if (we && a == wa(w, 5'h14) && d[0]) m_done[w] = 1'b0;
            if (we && a == wa(w, 5'h18)) m_den[w] = d[0];
            m_stat[w] = nxt;
        end
        nrdy = m_req & lnk_ready;
        if (we && a == 12'hF88) m_req = d[0];
        if (we && a == 12'hF98) m_cen = d[2];
        m_rdy = nrdy;
        @(negedge clk);
        bus_we = 1'b0; rx_clr_en = 1'b0;
        for (int w = 0; w < NWIN; w++)
            chk("R3 link word", lnk_stat[w*32 +: 32], m_stat[w]);
        chk("R6 irq pin", {31'b0, irq}, {31'b0, exp_irq()});
        chk("R8 lnk_req", {31'b0, lnk_req}, {31'b0, m_req});
    endtask

    task automatic sweep();
        for (int w = 0; w < NWIN; w++) begin
            rd(wa(w, 5'h00), m_stat[w], "R1 status readback");
            rd(wa(w, 5'h10), {31'b0, m_done[w]}, "R5 done flag");
            rd(wa(w, 5'h18), {31'b0, m_den[w]}, "R6 enable readback");
        end
        rd(12'hFA0, exp_comb(), "R6 combined word");
        rd(12'hF8C, {31'b0, m_rdy}, "R8 ready readback");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int w = 0; w < NWIN; w++) begin
            m_stat[w] = '0; m_done[w] = 1'b0; m_den[w] = 1'b0;
        end
        m_req = 1'b0; m_rdy = 1'b0; m_cen = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // reset state and identification (R1, R4)
        sweep();
        rd(12'hF80, 32'd4, "R4 window count");
        rd(12'hFCC, 32'h21, "R4 revision");
        rd(wa(1, 5'h04), 32'h0, "R1 unused offset");
        chk("R6 irq reset", {31'b0, irq}, 32'h0);

        // R7: set dropped without access
        cyc(1, wa(0, 5'h0C), 32'hA5, 0, 0, 0);
        rd(wa(0, 5'h00), 32'h0, "R7 set ignored");

        // R8: ready waits for receiver
        lnk_ready = 1'b0;
        cyc(1, 12'hF88, 32'h1, 0, 0, 0);
        cyc(0, 12'h000, 0, 0, 0, 0);
        rd(12'hF8C, 32'h0, "R8 not ready without receiver");
        lnk_ready = 1'b1;
        cyc(0, 12'h000, 0, 0, 0, 0);
        rd(12'hF8C, 32'h1, "R8 ready after receiver");

        // R2: OR semantics
        cyc(1, wa(2, 5'h0C), 32'h10, 0, 0, 0);
        cyc(1, wa(2, 5'h0C), 32'h01, 0, 0, 0);
        cyc(1, wa(2, 5'h0C), 32'h00, 0, 0, 0);
        rd(wa(2, 5'h00), 32'h11, "R2 or-in");

        // R3: partial clear, then set wins over clear
        cyc(0, 12'h0, 0, 1, 2, 32'h10);
        rd(wa(2, 5'h00), 32'h01, "R3 partial clear");
        cyc(1, wa(2, 5'h0C), 32'h01, 1, 2, 32'h01);
        rd(wa(2, 5'h00), 32'h01, "R3 set beats clear");

        // R5/R6: done flag, enables, interrupt
        cyc(1, wa(2, 5'h18), 32'h1, 0, 0, 0);
        cyc(0, 12'h0, 0, 1, 2, 32'hFFFF_FFFF);
        rd(wa(2, 5'h10), 32'h1, "R5 done on empty");
        chk("R6 irq gated off", {31'b0, irq}, 32'h0);
        cyc(1, 12'hF98, 32'h4, 0, 0, 0);
        rd(12'hFA0, 32'h4, "R6 combined bit 2");
        chk("R6 irq raised", {31'b0, irq}, 32'h1);
        cyc(1, wa(2, 5'h14), 32'h1, 0, 0, 0);
        rd(wa(2, 5'h10), 32'h0, "R5 flag cleared");

        // R5: done event beats flag clear
        cyc(1, wa(3, 5'h0C), 32'h8, 0, 0, 0);
        cyc(1, wa(3, 5'h14), 32'h1, 1, 3, 32'h8);
        rd(wa(3, 5'h10), 32'h1, "R5 event beats clear");

        // random phase
        for (int i = 0; i < 600; i++) begin
            int op = $urandom % 8;
            int w  = $urandom % NWIN;
            logic [31:0] r = $urandom & $urandom;
            logic [31:0] m = ($urandom % 2) ? 32'hFFFF_FFFF : $urandom;
            case (op)
                0, 1, 2: cyc(1, wa(w, 5'h0C), r, 0, 0, 0);
                3:       cyc(0, 12'h0, 0, 1, w, m);
                4:       cyc(1, wa(w, 5'h14), $urandom, 0, 0, 0);
                5:       cyc(1, wa(w, 5'h18), $urandom, 0, 0, 0);
                6:       cyc(1, wa(w, 5'h0C), r, 1, w, m);
                default: cyc(1, 12'hF98, $urandom, ($urandom % 2) == 1, w, m);
            endcase
            if (i % 8 == 7) sweep();
        end

        // R8: release drops ready, then sets are dropped (R7)
        cyc(1, 12'hF88, 32'h0, 0, 0, 0);
        rd(12'hF8C, 32'h1, "R8 ready lingers one cycle");
        cyc(0, 12'h0, 0, 0, 0, 0);
        rd(12'hF8C, 32'h0, "R8 released");
        cyc(1, wa(1, 5'h0C), 32'h8000_0000, 0, 0, 0);
        sweep();

        $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
        $finish;
    end
endmodule